// File: doc/BRIEF.md
# Frame-Processor Register Access Unit

This block is the load/store stage of a small embedded frame processor. Each read or write instruction carries an 8-bit address. The unit decodes that address. Locations whose top bit is set belong to a handful of registers held inside the unit. All other locations are passed to an external register bus. That bus has separate read and write strobes and waits for a ready input before the instruction completes.

The internal registers are two 16-bit general-purpose words and a 32-bit status/control word. The status/control word is split into two 16-bit halves. Every status bit drives a module output. Three of those bits are also given named flag outputs: processing complete, transport checksum good, and transport checksum checked and found bad.

A write instruction can take its data from either half of the status word instead of its own data field. This lets firmware forward status to an internal register or an external one.

The `busy` output is high while an external access is outstanding. The instruction pointer uses it to stall. An internal access completes in a single cycle.

Top module: `frac_regaccess`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. Addresses 00h to 7Fh (address bit 7 clear) produce an external access. Addresses 80h to FFh never raise `ext_rd` or `ext_wr`.
- R2: After an external request is accepted, the matching strobe (`ext_rd` for a read, `ext_wr` for a write) rises in the following cycle, with `ext_addr` equal to the request address and `busy` high. The strobe, `ext_addr` and `ext_wdata` hold their values until `ext_ready` is sampled high. One cycle after that sample, the strobe and `busy` are both low.
- R3: An external read raises `rd_valid` for one cycle, starting the cycle after the edge at which `ext_ready` is sampled high. During that cycle `rd_data` equals the `ext_rdata` value present at that edge.
- R4: An internal access completes in one cycle and `busy` stays low throughout. An internal read raises `rd_valid` in the cycle after acceptance. A write of any kind never raises `rd_valid`.
- R5: General register 1 is at 80h and general register 2 is at 81h. Each is 16 bits wide, reads back the last value written to it, and resets to 0.
- R6: Status bits 15:0 are at 82h and status bits 31:16 are at 83h. Both halves are readable and writable, and `status_o[31:0]` always reflects the whole status word.
- R7: Internal addresses 84h to FFh read as 0000h. Writes to them change no register.
- R8: `req_wsrc` selects the write data. The value 2'b10 selects status[15:0], 2'b11 selects status[31:16], and 2'b00 or 2'b01 selects `req_wdata`. The selection applies to both internal writes and external writes (`ext_wdata`).
- R9: `flag_done` equals status bit 15, `flag_csum_ok` equals status bit 11, and `flag_csum_bad` equals status bit 13.
- R10: A request presented while `busy` is high is ignored. It leaves every register unchanged and does not disturb the outstanding external access.
- R11: After reset, the following are all low or zero: `busy`, `rd_valid`, both strobes, both general registers and the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Instruction presents a read or write |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Target address |
| req_wsrc | input | 2 | Write data source select |
| req_wdata | input | 16 | Instruction write data |
| busy | output | 1 | External access outstanding |
| rd_valid | output | 1 | Read result valid this cycle |
| rd_data | output | 16 | Read result |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_addr | output | 8 | External address |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| ext_ready | input | 1 | External access complete |
| status_o | output | 32 | Status/control word |
| flag_done | output | 1 | Processing complete flag |
| flag_csum_ok | output | 1 | Transport checksum good flag |
| flag_csum_bad | output | 1 | Transport checksum bad flag |

## Verification
The hardest situation to reach from the ports is a new request arriving in the middle of an external wait. The processor normally stalls on `busy`, so such a request would never be presented in practice. To reach it, the bench drives an internal write to 80h during the first wait cycle of a slow external read. It then confirms three things: the strobe and address held steady, the read data came back unchanged, and a later read of 80h returns the old value. External accesses are swept over all 128 low addresses, with the ready latency rotating between zero and three extra cycles. Internal accesses are swept over all 128 high addresses.

// File: rtl/frac_pkg.sv
package frac_pkg;
  typedef enum logic [1:0] {
    WSRC_DATA    = 2'b00,
    WSRC_DATA_B  = 2'b01,
    WSRC_STAT_LO = 2'b10,
    WSRC_STAT_HI = 2'b11
  } wsrc_e;

  typedef enum logic {
    EXT_IDLE = 1'b0,
    EXT_WAIT = 1'b1
  } ext_state_e;
endpackage

// File: rtl/frac_addr_dec.sv
module frac_addr_dec #(
  parameter int ADDR_W = 8,
  parameter int NWORDS = 4,
  localparam int OFF_W = ADDR_W - 1,
  localparam int IW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_int,
  output logic              int_hit,
  output logic [IW-1:0]     int_idx
);
  function automatic logic [OFF_W-1:0] offset_of(logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  logic [OFF_W-1:0] off;

  always_comb begin
    off     = offset_of(addr);
    is_int  = addr[ADDR_W-1];
    int_hit = is_int && (off < OFF_W'(NWORDS));
    int_idx = off[IW-1:0];
  end
endmodule

// File: rtl/frac_int_regs.sv
module frac_int_regs #(
  parameter int DATA_W     = 16,
  parameter int NUM_GEN    = 2,
  parameter int STAT_WORDS = 2,
  localparam int NWORDS = NUM_GEN + STAT_WORDS,
  localparam int IW     = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int STAT_W = DATA_W * STAT_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              hit,
  input  logic [IW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [STAT_W-1:0] status
);
  logic [DATA_W-1:0] words [NWORDS];

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (we && hit && (idx == IW'(k)))
        q <= wdata;
    end
    assign words[k] = q;
  end

  for (genvar s = 0; s < STAT_WORDS; s++) begin : g_stat
    assign status[s*DATA_W +: DATA_W] = words[NUM_GEN + s];
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NWORDS; k++)
      if (hit && (idx == IW'(k))) rdata = words[k];
  end
endmodule

// File: rtl/frac_ext_port.sv
module frac_ext_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              issue_wr,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [DATA_W-1:0] issue_wdata,
  input  logic              ext_ready,
  output logic              busy,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              rd_done
);
  import frac_pkg::*;

  ext_state_e        state_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              finish;

  assign finish = (state_q == EXT_WAIT) && ext_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EXT_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (state_q)
        EXT_IDLE: if (issue) begin
          state_q <= EXT_WAIT;
          wr_q    <= issue_wr;
          addr_q  <= issue_addr;
          wdata_q <= issue_wdata;
        end
        EXT_WAIT: if (finish) state_q <= EXT_IDLE;
        default:  state_q <= EXT_IDLE;
      endcase
    end
  end

  assign busy      = (state_q == EXT_WAIT);
  assign ext_rd    = busy && !wr_q;
  assign ext_wr    = busy && wr_q;
  assign ext_addr  = addr_q;
  assign ext_wdata = wdata_q;
  assign rd_done   = finish && !wr_q;
endmodule

// File: rtl/frac_regaccess.sv
module frac_regaccess #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int NUM_GEN    = 2,
  parameter int STAT_WORDS = 2,
  parameter int DONE_BIT   = 15,
  parameter int OK_BIT     = 11,
  parameter int BAD_BIT    = 13,
  localparam int NWORDS = NUM_GEN + STAT_WORDS,
  localparam int IW     = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int STAT_W = DATA_W * STAT_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_wsrc,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic [DATA_W-1:0] ext_rdata,
  input  logic              ext_ready,
  output logic [STAT_W-1:0] status_o,
  output logic              flag_done,
  output logic              flag_csum_ok,
  output logic              flag_csum_bad
);
  import frac_pkg::*;

  function automatic logic [DATA_W-1:0] pick_wdata(wsrc_e s, logic [DATA_W-1:0] d,
                                                   logic [STAT_W-1:0] st);
    case (s)
      WSRC_STAT_LO: return st[DATA_W-1:0];
      WSRC_STAT_HI: return st[STAT_W-1 -: DATA_W];
      default:      return d;
    endcase
  endfunction

  logic              accept;
  logic              dec_is_int;
  logic              dec_hit;
  logic [IW-1:0]     dec_idx;
  logic [DATA_W-1:0] wdata_sel;
  logic              int_we;
  logic              int_rd_acc;
  logic              ext_issue;
  logic              ext_rd_done;
  logic [DATA_W-1:0] int_rdata;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  assign accept     = req_valid && !busy;
  assign wdata_sel  = pick_wdata(wsrc_e'(req_wsrc), req_wdata, status_o);
  assign int_we     = accept && req_write && dec_is_int;
  assign int_rd_acc = accept && !req_write && dec_is_int;
  assign ext_issue  = accept && !dec_is_int;

  frac_addr_dec #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) dec_i (
    .addr    (req_addr),
    .is_int  (dec_is_int),
    .int_hit (dec_hit),
    .int_idx (dec_idx)
  );

  frac_int_regs #(.DATA_W(DATA_W), .NUM_GEN(NUM_GEN), .STAT_WORDS(STAT_WORDS)) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (int_we),
    .hit    (dec_hit),
    .idx    (dec_idx),
    .wdata  (wdata_sel),
    .rdata  (int_rdata),
    .status (status_o)
  );

  frac_ext_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ext_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (ext_issue),
    .issue_wr    (req_write),
    .issue_addr  (req_addr),
    .issue_wdata (wdata_sel),
    .ext_ready   (ext_ready),
    .busy        (busy),
    .ext_rd      (ext_rd),
    .ext_wr      (ext_wr),
    .ext_addr    (ext_addr),
    .ext_wdata   (ext_wdata),
    .rd_done     (ext_rd_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      if (int_rd_acc) begin
        rd_valid_q <= 1'b1;
        rd_data_q  <= int_rdata;
      end else if (ext_rd_done) begin
        rd_valid_q <= 1'b1;
        rd_data_q  <= ext_rdata;
      end
    end
  end

  assign rd_valid      = rd_valid_q;
  assign rd_data       = rd_data_q;
  assign flag_done     = status_o[DONE_BIT];
  assign flag_csum_ok  = status_o[OK_BIT];
  assign flag_csum_bad = status_o[BAD_BIT];
endmodule

// File: rtl/frac_regaccess_chk.sv
module frac_regaccess_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              busy,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              ext_rd,
  input logic              ext_wr,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [DATA_W-1:0] ext_rdata,
  input logic              ext_ready,
  input logic [STAT_W-1:0] status_o
);
  p_int_no_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && req_addr[ADDR_W-1] |=> !ext_rd && !ext_wr && !busy);

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_rd && ext_wr));

  p_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && !req_addr[ADDR_W-1]
      |=> busy && (ext_rd == !$past(req_write)) && (ext_wr == $past(req_write))
          && ext_addr == $past(req_addr));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd || ext_wr) && !ext_ready |=> $stable(ext_addr) && $stable(ext_rd) && $stable(ext_wr));

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd || ext_wr) && ext_ready |=> !busy && !ext_rd && !ext_wr);

  p_ext_addr_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd || ext_wr) |-> !ext_addr[ADDR_W-1]);

  p_read_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd && ext_ready |=> rd_valid && rd_data == $past(ext_rdata));

  p_int_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && req_addr[ADDR_W-1] && !req_write |=> rd_valid);

  p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && req_write |=> !rd_valid);

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ext_ready |=> $stable(status_o));
endmodule

bind frac_regaccess frac_regaccess_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .ext_rd    (ext_rd),
  .ext_wr    (ext_wr),
  .ext_addr  (ext_addr),
  .ext_rdata (ext_rdata),
  .ext_ready (ext_ready),
  .status_o  (status_o)
);

// File: tb/frac_regaccess_tb.sv
`timescale 1ns/1ps
module frac_regaccess_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_wsrc = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, rd_valid, ext_rd, ext_wr;
  logic [15:0] rd_data, ext_wdata;
  logic [7:0]  ext_addr;
  logic [15:0] ext_rdata = 16'hFFFF;
  logic        ext_ready = 1'b0;
  logic [31:0] status_o;
  logic        flag_done, flag_csum_ok, flag_csum_bad;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_gen1 = '0;
  logic [15:0] m_gen2 = '0;
  logic [31:0] m_stat = '0;

  always #2.5 clk = ~clk;

  frac_regaccess dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wsrc(req_wsrc), .req_wdata(req_wdata),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata), .ext_ready(ext_ready), .status_o(status_o),
    .flag_done(flag_done), .flag_csum_ok(flag_csum_ok), .flag_csum_bad(flag_csum_bad)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] src_data(input logic [1:0] s, input logic [15:0] d);
    if (s == 2'b10) return m_stat[15:0];
    if (s == 2'b11) return m_stat[31:16];
    return d;
  endfunction

  function automatic logic [15:0] model_read(input logic [7:0] a);
    case (a)
      8'h80: return m_gen1;
      8'h81: return m_gen2;
      8'h82: return m_stat[15:0];
      8'h83: return m_stat[31:16];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check_flags();
    chk("R6 status_o", status_o, m_stat);
    chk("R9 flag_done", {31'd0, flag_done}, {31'd0, m_stat[15]});
    chk("R9 flag_csum_ok", {31'd0, flag_csum_ok}, {31'd0, m_stat[11]});
    chk("R9 flag_csum_bad", {31'd0, flag_csum_bad}, {31'd0, m_stat[13]});
  endtask

  task automatic int_access(input bit wr, input logic [7:0] a, input logic [1:0] s,
                            input logic [15:0] d);
    logic [15:0] v;
    logic [15:0] expr;
    v = src_data(s, d);
    expr = model_read(a);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wsrc = s; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      case (a)
        8'h80: m_gen1 = v;
        8'h81: m_gen2 = v;
        8'h82: m_stat[15:0] = v;
        8'h83: m_stat[31:16] = v;
        default: ;
      endcase
    end
    chk("R4 busy low", {31'd0, busy}, 32'd0);
    chk("R1 no strobe", {30'd0, ext_rd, ext_wr}, 32'd0);
    chk("R4 rd_valid", {31'd0, rd_valid}, {31'd0, !wr});
    if (!wr) chk("R5/R6/R7 read data", {16'd0, rd_data}, {16'd0, expr});
  endtask

  task automatic ext_access(input bit wr, input logic [7:0] a, input logic [1:0] s,
                            input logic [15:0] d, input int lat, input bit inject);
    logic [15:0] v;
    logic [15:0] rv;
    v  = src_data(s, d);
    rv = 16'h1000 + 16'(a) * 16'd3;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wsrc = s; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int w = 0; w <= lat; w++) begin
      chk("R2 strobe", {30'd0, ext_rd, ext_wr}, wr ? 32'd1 : 32'd2);
      chk("R2 ext_addr", {24'd0, ext_addr}, {24'd0, a});
      chk("R2 busy", {31'd0, busy}, 32'd1);
      if (wr) chk("R8 ext_wdata", {16'd0, ext_wdata}, {16'd0, v});
      if (inject && w == 0) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h80;
        req_wsrc = 2'b00; req_wdata = 16'hDEAD;
      end
      if (w == lat) begin
        ext_ready = 1'b1;
        ext_rdata = rv;
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (w != lat) chk("R3 no early rd_valid", {31'd0, rd_valid}, 32'd0);
    end
    ext_ready = 1'b0;
    ext_rdata = 16'hFFFF;
    chk("R2 release busy", {31'd0, busy}, 32'd0);
    chk("R2 release strobe", {30'd0, ext_rd, ext_wr}, 32'd0);
    chk("R3 rd_valid", {31'd0, rd_valid}, {31'd0, !wr});
    if (!wr) chk("R3 rd_data", {16'd0, rd_data}, {16'd0, rv});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", {31'd0, busy}, 32'd0);
    chk("R11 rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("R11 strobes", {30'd0, ext_rd, ext_wr}, 32'd0);
    chk("R11 status", status_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    int_access(1'b0, 8'h80, 2'b00, 16'h0);
    int_access(1'b0, 8'h81, 2'b00, 16'h0);

    // R5 R6 R7 internal sweep: write then read each high address
    for (int a = 128; a < 256; a++) begin
      int_access(1'b1, 8'(a), 2'b00, {8'(a), ~8'(a)});
      int_access(1'b0, 8'(a), 2'b00, 16'h0);
      check_flags();
    end
    for (int a = 128; a < 132; a++) int_access(1'b0, 8'(a), 2'b00, 16'h0);

    // R9 explicit flag patterns
    int_access(1'b1, 8'h82, 2'b00, 16'h2800);
    check_flags();
    int_access(1'b1, 8'h82, 2'b01, 16'h8800);
    check_flags();
    int_access(1'b1, 8'h83, 2'b00, 16'hA5C3);
    check_flags();

    // R8 write source selection, internal destinations
    int_access(1'b1, 8'h80, 2'b10, 16'h1111);
    int_access(1'b0, 8'h80, 2'b00, 16'h0);
    int_access(1'b1, 8'h81, 2'b11, 16'h2222);
    int_access(1'b0, 8'h81, 2'b00, 16'h0);
    int_access(1'b1, 8'h80, 2'b01, 16'h3333);
    int_access(1'b0, 8'h80, 2'b00, 16'h0);

    // R1 R2 R3 R8 external sweep with rotating latency
    for (int a = 0; a < 128; a++) begin
      ext_access(1'b1, 8'(a), 2'(a % 4), 16'(a) * 16'h0101 ^ 16'h5A5A, a % 4, 1'b0);
      ext_access(1'b0, 8'(a), 2'b00, 16'h0, (a + 1) % 4, 1'b0);
    end

    // R10 request during an external wait is ignored
    int_access(1'b1, 8'h80, 2'b00, 16'h4C4C);
    ext_access(1'b0, 8'h10, 2'b00, 16'h0, 3, 1'b1);
    int_access(1'b0, 8'h80, 2'b00, 16'h0);
    chk("R10 gen1 unchanged", {16'd0, m_gen1}, 32'h4C4C);
    check_flags();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule